// File: doc/BRIEF.md
# Multi-Input Edge Wake-Up Controller

This block watches a group of external input lines and records a chosen transition on each one. Each line has its own enable bit and its own edge-polarity bit. A transition of the selected direction sets a sticky pending bit for that line. The pending bits are masked by the enable bits and then merged into a single request line. That one line serves two purposes: the power manager uses it to leave its stopped or slowed modes, and the CPU can take it as an ordinary maskable edge interrupt.

The block runs entirely on one free-running clock that stays on in every low-power mode. This lets it see input transitions while the main system clock is gated. Before any edge is judged, each input passes through a synchronizer.

Software reaches the block through a small register port. There is no data stream and no back-pressure: a write is accepted in the cycle it is presented, and read data follows the address combinationally.

Top module: `edge_wake_ctrl`

## Requirements
- R1: After reset, the enable register reads all zeros, the polarity register reads all ones (every line set to rising), the pending register reads all zeros, and `wake_req` is 0.
- R2: An input change on line i is detected by the pending bit on the third rising clock edge after the change. Two synchronizer stages and one previous-level register account for this delay. The pending bit is still 0 after the second edge.
- R3: Polarity bit value 1 selects a 0-to-1 transition and value 0 selects a 1-to-0 transition. A transition in the other direction leaves the pending bit unchanged.
- R4: A pending bit is set whether or not its line is enabled. Once set, it stays set until software clears it.
- R5: Writing to address 2 clears each pending bit whose write-data bit is 1 and leaves bits written with 0 unchanged. A clear and a new detected edge on the same line in the same cycle leave the bit set.
- R6: `wake_req` is the OR over all lines of (pending AND enable). It follows register changes with no extra cycle.
- R7: Register addresses are: 0 = enable, 1 = polarity, 2 = pending. Address 3 reads as zero, and writes to it change nothing.
- R8: A line whose polarity bit is changed by a write ignores any edge that appears in the first cycle the new polarity is in force. Lines whose polarity bit was written with its current value are not affected.
- R9: Input levels that are present when reset is released never set a pending bit. Edge judging starts only after the synchronizer and the previous-level register hold real samples.
- R10: The lines are independent. An edge on one line changes only that line's pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_pins | input | NCH | Asynchronous external input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NCH | Register write data |
| reg_rdata | output | NCH | Register read data, combinational from reg_addr |
| wake_req | output | 1 | Combined wake-up / interrupt request |

## Verification
The bench builds the block with NCH = 4 and the default two-stage synchronizer. With four lines, every polarity mask, every enable mask and every clear mask (16 values each) can be swept in full. The sweep pairs each polarity mask with a rising and a falling edge on every line. The same small build is used to pin down the three-edge latency, the edge that is lost in the re-arm window, the case where a new edge and a clear land on the same line in the same cycle, and the quiet period after reset with inputs held high.

// File: rtl/ewk_pkg.sv
package ewk_pkg;
  localparam int unsigned EWK_ADDR_W = 2;

  typedef enum logic [EWK_ADDR_W-1:0] {
    REG_ENABLE = 2'd0,
    REG_EDGE   = 2'd1,
    REG_PEND   = 2'd2,
    REG_SPARE  = 2'd3
  } ewk_reg_e;
endpackage

// File: rtl/ewk_sync.sv
module ewk_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ewk_cfg.sv
module ewk_cfg
  import ewk_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [EWK_ADDR_W-1:0] addr_i,
  input  logic [NCH-1:0]        wdata_i,
  output logic [NCH-1:0]        en_o,
  output logic [NCH-1:0]        rise_o,
  output logic [NCH-1:0]        blk_o
);
  logic [NCH-1:0] en_q, rise_q, blk_q;
  logic           wr_en, wr_edge;

  assign wr_en   = wr_i && (addr_i == REG_ENABLE);
  assign wr_edge = wr_i && (addr_i == REG_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      rise_q <= '1;
      blk_q  <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata_i;
      if (wr_edge) rise_q <= wdata_i;
      // only lines whose polarity really flips sit out one cycle
      blk_q <= wr_edge ? (rise_q ^ wdata_i) : '0;
    end
  end

  assign en_o   = en_q;
  assign rise_o = rise_q;
  assign blk_o  = blk_q;

  p_blk_after_edge_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q != '0) |-> $past(wr_i && addr_i == REG_EDGE));

  p_spare_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == REG_SPARE) |=> ($stable(en_q) && $stable(rise_q)));
endmodule

// File: rtl/ewk_chan.sv
module ewk_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, hit;

  assign hit = arm_i && (rise_i ? (lvl_i && !prev_q) : (!lvl_i && prev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (hit)        pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  p_set_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(arm_i && (lvl_i != prev_q)));

  p_pending_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);

  p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (lvl_i == prev_q)) |=> !pend_q);

  p_disarmed_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_i && !clr_i) |=> $stable(pend_q));
endmodule

// File: rtl/edge_wake_ctrl.sv
module edge_wake_ctrl
  import ewk_pkg::*;
#(
  parameter int unsigned NCH         = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        wake_pins,
  input  logic                  reg_wr,
  input  logic [EWK_ADDR_W-1:0] reg_addr,
  input  logic [NCH-1:0]        reg_wdata,
  output logic [NCH-1:0]        reg_rdata,
  output logic                  wake_req
);
  localparam int unsigned WARM_MAX = SYNC_STAGES + 1;
  localparam int unsigned CW       = $clog2(WARM_MAX + 1);

  logic [NCH-1:0] lvl, en, rise, blk, clr_vec, pend_vec;
  logic [CW-1:0]  warm_q;
  logic           warm_done;

  ewk_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (wake_pins),
    .dout (lvl)
  );

  ewk_cfg #(.NCH(NCH)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (reg_wr),
    .addr_i (reg_addr),
    .wdata_i(reg_wdata),
    .en_o   (en),
    .rise_o (rise),
    .blk_o  (blk)
  );

  // hold off edge judging until sync chain and previous-level register are filled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    warm_q <= '0;
    else if (warm_q != CW'(WARM_MAX)) warm_q <= warm_q + CW'(1);
  end
  assign warm_done = (warm_q == CW'(WARM_MAX));

  assign clr_vec = (reg_wr && reg_addr == REG_PEND) ? reg_wdata : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    ewk_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (lvl[g]),
      .rise_i(rise[g]),
      .arm_i (warm_done && !blk[g]),
      .clr_i (clr_vec[g]),
      .pend_o(pend_vec[g])
    );
  end

  assign wake_req = |(pend_vec & en);

  always_comb begin
    case (reg_addr)
      REG_ENABLE: reg_rdata = en;
      REG_EDGE:   reg_rdata = rise;
      REG_PEND:   reg_rdata = pend_vec;
      default:    reg_rdata = '0;
    endcase
  end

  p_warmup_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_done |-> (pend_vec == '0));

  p_wake_off_when_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !wake_req);
endmodule

// File: tb/test_edge_wake_ctrl.sv
module test_edge_wake_ctrl;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] wake_pins = '0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         wake_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  edge_wake_ctrl #(.NCH(N), .SYNC_STAGES(2)) i_edge_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .wake_pins(wake_pins),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wake_req(wake_req)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a[1:0]; reg_wdata = d[N-1:0];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    reg_addr = a[1:0];
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic pins_set(int v);
    @(negedge clk);
    wake_pins = v[N-1:0];
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int v, exp_p;
    wake_pins = 4'b1010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    rd(2, v); chk("R9 pending after reset with high inputs", v, 0);
    rd(0, v); chk("R1 enable reset", v, 0);
    rd(1, v); chk("R1 polarity reset", v, 15);
    chk("R1 wake_req reset", int'(wake_req), 0);

    // R2 latency: rising on line 0
    pins_set(0); wr(2, 15);
    @(negedge clk); wake_pins = 4'b0001;
    @(negedge clk);
    @(negedge clk); rd(2, v); chk("R2 not set after two edges", v, 0);
    @(negedge clk); rd(2, v); chk("R2 set on third edge", v, 1);

    // R5 set wins over same-cycle clear
    pins_set(0); rd(2, v); chk("R3 falling ignored under rising", v, 1);
    @(negedge clk); wake_pins = 4'b0001;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 4'b0001;
    @(negedge clk); reg_wr = 1'b0;
    rd(2, v); chk("R5 edge beats clear", v, 1);
    wr(2, 1); rd(2, v); chk("R5 clear alone", v, 0);

    // R3/R10 sweep of every polarity mask
    for (int pol = 0; pol < 16; pol++) begin
      pins_set(0); wr(1, pol); @(negedge clk); wr(2, 15);
      exp_p = 0;
      for (int ch = 0; ch < N; ch++) begin
        pins_set(1 << ch);
        if (pol[ch]) exp_p |= (1 << ch);
        rd(2, v); chk($sformatf("R3 R10 rise pol=%0d ch=%0d", pol, ch), v, exp_p);
        pins_set(0);
        if (!pol[ch]) exp_p |= (1 << ch);
        rd(2, v); chk($sformatf("R3 R10 fall pol=%0d ch=%0d", pol, ch), v, exp_p);
      end
    end

    // R4/R6 enable sweep with all pending (pending latched while disabled)
    wr(0, 0); wr(1, 15); @(negedge clk); wr(2, 15);
    pins_set(15);
    rd(2, v); chk("R4 pending set while disabled", v, 15);
    chk("R6 no wake when disabled", int'(wake_req), 0);
    for (int m = 0; m < 16; m++) begin
      wr(0, m);
      rd(0, v); chk($sformatf("R7 enable readback m=%0d", m), v, m);
      chk($sformatf("R6 wake en=%0d", m), int'(wake_req), (m != 0) ? 1 : 0);
    end
    repeat (5) @(negedge clk);
    rd(2, v); chk("R4 pending sticky", v, 15);

    // R5 clear-mask sweep
    for (int c = 0; c < 16; c++) begin
      pins_set(0); pins_set(15);
      rd(2, v); chk($sformatf("R5 refill c=%0d", c), v, 15);
      wr(2, c);
      rd(2, v); chk($sformatf("R5 clear mask=%0d", c), v, 15 & ~c);
      wr(0, 1 << (c % N));
      chk($sformatf("R6 single enable c=%0d", c), int'(wake_req),
          (((15 & ~c) >> (c % N)) & 1));
      wr(0, 15);
    end

    // R8 re-arm window: line 0 flips to rising, line 1 stays rising
    wr(2, 15); pins_set(0); wr(1, 4'b0010); @(negedge clk);
    @(negedge clk); wake_pins = 4'b0011;
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 4'b0011;
    @(negedge clk); reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rd(2, v); chk("R8 changed line skips edge, unchanged line keeps it", v, 2);

    // R7 spare address
    wr(0, 4'b0101); wr(1, 4'b1001);
    wr(3, 15);
    rd(3, v); chk("R7 spare reads zero", v, 0);
    rd(0, v); chk("R7 spare write leaves enable", v, 5);
    rd(1, v); chk("R7 spare write leaves polarity", v, 9);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule